// File: doc/BRIEF.md
# Register Hazard Scoreboard

This block is the register-state table an in-order issue stage consults before it lets an instruction go. Each architectural register above register 0 has two pieces of state: a small count of in-flight instructions that have yet to read it, and a flag saying that an in-flight instruction will write it. The issue stage presents two source register indices and one destination index. The block answers combinationally whether that instruction may issue, judging only from register state. Functional units are taken to be always free.

When a valid request is granted, the block adds one to the reader count of each named source register, or two when both sources name the same register. It also sets the pending-write flag of the destination, and all of this lands in the same clock edge. Later the pipeline reports individual reads finishing on a read-done port and results landing on a write-back port, which release that state. Register 0 stands for "no operand": it is never tracked and never blocks.

Top module: `reg_hazard_table`

## Requirements
- R1: After reset every reader count is zero and no write is pending, so any request is granted.
- R2: A request whose source register (non-zero) has a pending write is refused (read-after-write).
- R3: A request whose destination register (non-zero) has a non-zero reader count is refused (write-after-read).
- R4: A request whose destination register (non-zero) has a pending write is refused (write-after-write).
- R5: A granted request adds one to the reader count of each non-zero source, two when both sources are the same register, and sets the destination's pending flag; the new state governs the decision from the next cycle.
- R6: A read-done pulse lowers that register's reader count by one; a read-done on a register whose count is zero has no effect.
- R7: A write-back pulse clears that register's pending-write flag.
- R8: Register index 0 in any operand position never causes a refusal and never changes state.
- R9: With 3-bit reader counts (limit 7), a request is refused when its increments would take a source's count above 7.
- R10: A request with req_valid_i low, or one that is refused, leaves all state unchanged.
- R11: The decision uses the registered state: a read-done or write-back arriving in the same cycle as a request takes effect only from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | An instruction is presented for issue |
| src_a_i | input | 4 | First source register index, 0 means none |
| src_b_i | input | 4 | Second source register index, 0 means none |
| dst_i | input | 4 | Destination register index, 0 means none |
| issue_ok_o | output | 1 | Presented operands are free of hazards; issue happens when req_valid_i is also high |
| rd_done_i | input | 1 | One outstanding read has finished |
| rd_done_reg_i | input | 4 | Register whose read finished |
| wb_i | input | 1 | A result has been written back |
| wb_reg_i | input | 4 | Register that was written back |

## Verification
The refusal for counter overflow is the hardest case to reach. It only appears after several granted reads of one register pile up with no read-done in between, so random traffic that releases reads freely seldom gets there. A directed run issues repeated double reads of a single register to bring its count to 6. It then tries another double read, which must be refused, and a single read, which must be granted and bring the count to 7. A long pseudo-random phase follows, with read-done pulses sent only rarely so that counts rise, and a reference model checks the grant on every cycle. Same-cycle release and request, and read-done on an empty count, are also driven directly.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef struct packed {
    logic raw;
    logic war;
    logic waw;
    logic ovf;
  } hzd_cause_t;
endpackage

// File: rtl/hzd_decode.sv
module hzd_decode #(
  parameter int unsigned NUM   = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             en_i,
  output logic [NUM-1:0]   oh_o
);
  // entry 0 is never selected
  always_comb begin
    oh_o = '0;
    for (int i = 1; i < NUM; i++) begin
      if (en_i && (idx_i == IDX_W'(i))) oh_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/hzd_entry.sv
module hzd_entry
  import hzd_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       src_hits_i,
  input  logic             dst_hit_i,
  input  logic             issue_i,
  input  logic             rd_hit_i,
  input  logic             wb_hit_i,
  output hzd_cause_t       cause_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic [CNT_W:0]   sum;
  logic [1:0]       inc;
  logic             dec;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(src_hits_i);

  always_comb begin
    cause_o.raw = (src_hits_i != 2'd0) && pend_q;
    cause_o.war = dst_hit_i && (cnt_q != '0);
    cause_o.waw = dst_hit_i && pend_q;
    cause_o.ovf = (sum > (CNT_W+1)'(CNT_MAX));
  end

  assign inc    = issue_i ? src_hits_i : 2'd0;
  assign dec    = rd_hit_i && (cnt_q != '0);
  assign cnt_d  = cnt_q + CNT_W'(inc) - CNT_W'(dec);
  assign pend_d = (pend_q && !wb_hit_i) || (issue_i && dst_hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/reg_hazard_table.sv
module reg_hazard_table
  import hzd_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned CNT_W    = 3,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] src_a_i,
  input  logic [IDX_W-1:0] src_b_i,
  input  logic [IDX_W-1:0] dst_i,
  output logic             issue_ok_o,
  input  logic             rd_done_i,
  input  logic [IDX_W-1:0] rd_done_reg_i,
  input  logic             wb_i,
  input  logic [IDX_W-1:0] wb_reg_i
);
  logic [NUM_REGS-1:0] a_oh, b_oh, d_oh, rd_oh, wb_oh;
  logic [NUM_REGS-1:0] raw_v, war_v, waw_v, ovf_v;
  logic [NUM_REGS-1:0] pend_vec;
  logic [CNT_W-1:0]    cnt_vec [NUM_REGS];
  logic                issue_go;

  hzd_decode #(.NUM(NUM_REGS), .IDX_W(IDX_W)) u_dec_a
    (.idx_i(src_a_i), .en_i(1'b1), .oh_o(a_oh));
  hzd_decode #(.NUM(NUM_REGS), .IDX_W(IDX_W)) u_dec_b
    (.idx_i(src_b_i), .en_i(1'b1), .oh_o(b_oh));
  hzd_decode #(.NUM(NUM_REGS), .IDX_W(IDX_W)) u_dec_d
    (.idx_i(dst_i), .en_i(1'b1), .oh_o(d_oh));
  hzd_decode #(.NUM(NUM_REGS), .IDX_W(IDX_W)) u_dec_rd
    (.idx_i(rd_done_reg_i), .en_i(rd_done_i), .oh_o(rd_oh));
  hzd_decode #(.NUM(NUM_REGS), .IDX_W(IDX_W)) u_dec_wb
    (.idx_i(wb_reg_i), .en_i(wb_i), .oh_o(wb_oh));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign raw_v[g]    = 1'b0;
      assign war_v[g]    = 1'b0;
      assign waw_v[g]    = 1'b0;
      assign ovf_v[g]    = 1'b0;
      assign pend_vec[g] = 1'b0;
      assign cnt_vec[g]  = '0;
    end else begin : g_trk
      hzd_cause_t cause;
      hzd_entry #(.CNT_W(CNT_W)) u_entry (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_hits_i ({1'b0, a_oh[g]} + {1'b0, b_oh[g]}),
        .dst_hit_i  (d_oh[g]),
        .issue_i    (issue_go),
        .rd_hit_i   (rd_oh[g]),
        .wb_hit_i   (wb_oh[g]),
        .cause_o    (cause),
        .cnt_o      (cnt_vec[g]),
        .pend_o     (pend_vec[g])
      );
      assign raw_v[g] = cause.raw;
      assign war_v[g] = cause.war;
      assign waw_v[g] = cause.waw;
      assign ovf_v[g] = cause.ovf;
    end
  end

  assign issue_ok_o = !(|raw_v || |war_v || |waw_v || |ovf_v);
  assign issue_go   = req_valid_i && issue_ok_o;
endmodule

// File: rtl/reg_hazard_table_chk.sv
module reg_hazard_table_chk #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned IDX_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [IDX_W-1:0] src_a_i,
  input logic [IDX_W-1:0] src_b_i,
  input logic [IDX_W-1:0] dst_i,
  input logic             issue_ok_o,
  input logic             wb_i,
  input logic [IDX_W-1:0] wb_reg_i,
  input logic [NUM_REGS-1:0] pend_vec,
  input logic [CNT_W-1:0] cnt_vec [NUM_REGS]
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
  logic go;
  assign go = req_valid_i && issue_ok_o;

  assert_raw_block_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && src_a_i != '0 |-> !pend_vec[src_a_i]);

  assert_dst_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && dst_i != '0 |-> cnt_vec[dst_i] == '0 && !pend_vec[dst_i]);

  assert_dst_marked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && dst_i != '0 |=> pend_vec[$past(dst_i)]);

  assert_wb_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_i && wb_reg_i != '0 && !(go && dst_i == wb_reg_i) |=> !pend_vec[$past(wb_reg_i)]);

  assert_zero_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_a_i == '0 && src_b_i == '0 && dst_i == '0 |-> issue_ok_o);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && src_a_i != '0 && src_a_i == src_b_i |-> int'(cnt_vec[src_a_i]) <= int'(CNT_MAX) - 2);
endmodule

bind reg_hazard_table reg_hazard_table_chk #(
  .NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
  .issue_ok_o(issue_ok_o), .wb_i(wb_i), .wb_reg_i(wb_reg_i),
  .pend_vec(pend_vec), .cnt_vec(cnt_vec)
);

// File: tb/reg_hazard_table_bench.sv
module reg_hazard_table_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_LIMIT  = 7;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [3:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic       issue_ok_o;
  logic       rd_done_i = 1'b0;
  logic [3:0] rd_done_reg_i = '0;
  logic       wb_i = 1'b0;
  logic [3:0] wb_reg_i = '0;

  int checks = 0;
  int fails  = 0;
  int m_cnt [16];
  bit m_pend [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_hazard_table u_reg_hazard_table (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
    .issue_ok_o(issue_ok_o), .rd_done_i(rd_done_i),
    .rd_done_reg_i(rd_done_reg_i), .wb_i(wb_i), .wb_reg_i(wb_reg_i)
  );

  function automatic bit model_ok(int a, int b, int d);
    bit ok = 1'b1;
    if (a != 0 && m_pend[a]) ok = 1'b0;
    if (b != 0 && m_pend[b]) ok = 1'b0;
    if (d != 0 && (m_cnt[d] != 0 || m_pend[d])) ok = 1'b0;
    if (a != 0 && a == b) begin
      if (m_cnt[a] + 2 > CNT_LIMIT) ok = 1'b0;
    end else begin
      if (a != 0 && m_cnt[a] + 1 > CNT_LIMIT) ok = 1'b0;
      if (b != 0 && m_cnt[b] + 1 > CNT_LIMIT) ok = 1'b0;
    end
    return ok;
  endfunction

  task automatic step(bit v, int a, int b, int d, bit rv, int rr, bit wv, int wr, string tag);
    bit exp_ok;
    int old;
    @(negedge clk);
    req_valid_i = v; src_a_i = 4'(a); src_b_i = 4'(b); dst_i = 4'(d);
    rd_done_i = rv; rd_done_reg_i = 4'(rr); wb_i = wv; wb_reg_i = 4'(wr);
    #1;
    exp_ok = model_ok(a, b, d);
    checks++;
    if (issue_ok_o !== exp_ok) begin
      fails++;
      $display("FAIL %s: issue_ok_o=%0b expected %0b (src %0d,%0d dst %0d)",
               tag, issue_ok_o, exp_ok, a, b, d);
    end
    @(posedge clk);
    if (rv && rr != 0) begin
      old = m_cnt[rr];
      if (old > 0) m_cnt[rr] = old - 1;
    end
    if (wv && wr != 0) m_pend[wr] = 1'b0;
    if (v && exp_ok) begin
      if (a != 0) m_cnt[a]++;
      if (b != 0) m_cnt[b]++;
      if (d != 0) m_pend[d] = 1'b1;
    end
  endtask

  task automatic probe(int a, int b, int d, string tag);
    step(1'b0, a, b, d, 1'b0, 0, 1'b0, 0, tag);
  endtask

  task automatic issue(int a, int b, int d, string tag);
    step(1'b1, a, b, d, 1'b0, 0, 1'b0, 0, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10: watchdog expired, actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_cnt[i] = 0; m_pend[i] = 1'b0; end
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R1 reset state, R10 probes without valid change nothing
    probe(1, 2, 3, "R1");
    probe(15, 15, 15, "R1");
    probe(7, 7, 7, "R10");
    // R5 issue and effect next cycle
    issue(2, 3, 1, "R5");
    probe(1, 0, 0, "R2");
    probe(0, 0, 2, "R3");
    probe(0, 0, 1, "R4");
    issue(0, 1, 4, "R2");
    issue(0, 0, 3, "R10");
    // R6 release of a reader
    step(1'b0, 0, 0, 0, 1'b1, 2, 1'b0, 0, "R6");
    probe(0, 0, 2, "R6");
    // R11 same-cycle write-back does not unblock
    step(1'b1, 1, 0, 5, 1'b0, 0, 1'b1, 1, "R11");
    probe(1, 0, 5, "R7");
    issue(1, 0, 5, "R7");
    // R8 register zero
    issue(0, 0, 0, "R8");
    issue(0, 0, 0, "R8");
    probe(0, 0, 0, "R8");
    // R9 overflow on reg 9
    issue(9, 9, 0, "R9");
    issue(9, 9, 0, "R9");
    issue(9, 9, 0, "R9");
    issue(9, 9, 0, "R9");
    issue(9, 0, 0, "R9");
    issue(0, 9, 0, "R9");
    step(1'b0, 0, 0, 0, 1'b1, 9, 1'b0, 0, "R6");
    issue(9, 0, 0, "R9");
    // R6 read-done on empty count ignored
    step(1'b0, 0, 0, 0, 1'b1, 12, 1'b0, 0, "R6");
    probe(0, 0, 12, "R6");
    issue(0, 0, 12, "R6");
    step(1'b0, 0, 0, 0, 1'b0, 0, 1'b1, 12, "R7");

    // R10 random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int a = $urandom_range(0, 15);
      int b = ($urandom_range(0, 3) == 0) ? a : $urandom_range(0, 15);
      int d = $urandom_range(0, 15);
      bit rv = ($urandom_range(0, 3) == 0);
      bit wv = ($urandom_range(0, 2) == 0);
      step($urandom_range(0, 1) == 1, a, b, d, rv, $urandom_range(0, 15),
           wv, $urandom_range(0, 15), "R10");
    end
    finish_run();
  end
endmodule